// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

This block holds five PWM timer channels behind a small memory-mapped register port. Each channel owns two buffer registers, one for the period and one for the compare point, which software may rewrite at any time without disturbing the waveform being produced. The values take effect only when a channel loads its active counter and compare registers. That happens either on a manual-update strobe or automatically at the end of each period when auto-reload is set. Each channel counts down once per cycle in which its tick enable is high. The tick enables come from a prescaler outside this block.

A single control word gathers, for every channel, a start bit, a manual-update bit, an output-invert bit and an auto-reload bit. The layout of this word is irregular, and software depends on that layout. Channel 0 uses group 0. Channel n (n ≥ 1) uses group n+1, so group 1 (bits 7:4) is never used. The last channel has no invert bit, and its auto-reload bit sits where the other channels keep their invert bit. Two further 32-bit configuration words are stored and read back for the prescaler and clock-select logic that sits next to this block.

Each channel is a three-state machine:
- CH_IDLE: stopped or being loaded.
- CH_COUNT: running.
- CH_EXPIRED: the period finished with auto-reload off.

The transitions are:
- IDLE→COUNT: start set and no manual update.
- COUNT→IDLE and EXPIRED→IDLE: start cleared, or manual update.
- COUNT→EXPIRED: a tick at count zero with auto-reload clear.
- EXPIRED→EXPIRED: start held with no manual update.

Top module: `pwm_timer_bank`

## Requirements
- R1: Byte address 0x00 and 0x04 are 32-bit read/write configuration words. Channel n's period buffer is at 0x0C+12·n and its compare buffer at 0x10+12·n; both keep the low CNT_W bits of a write and read back zero-extended. Every other address reads zero.
- R2: In the control word at 0x08, channel 0 uses bits 3:0 and channel n≥1 uses bits 4(n+1)+3:4(n+1). Within a group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. Bits 7:4, bit 23 and bits 31:24 ignore writes and read zero.
- R3: The last channel (bits 23:20) has its auto-reload at bit 22 and has no invert bit; its output is never inverted.
- R4: While a channel's manual-update bit is set, its active counter and compare registers are loaded from the buffers on every clock, and the counter does not decrement.
- R5: A running channel (start set, no manual update, not expired) decrements its counter by one on each clock with its tick enable high. With start clear, or with the tick enable low, the counter holds.
- R6: When a running channel's counter is zero on a tick and auto-reload is set, both active registers reload from the buffers on that tick, so a period lasts period-buffer+1 ticks.
- R7: When a running channel's counter is zero on a tick and auto-reload is clear, the counter stays at zero and the channel stops (expires) until start is cleared or manual update is applied.
- R8: A channel's output is high when counter ≤ compare and low otherwise, XOR the invert bit. A compare value of all ones therefore gives a constant high level.
- R9: Reset clears every register. After reset all readable addresses return zero and every output is high (counter 0 ≤ compare 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_en | input | NUM_CH | Per-channel count enables from the prescaler |
| pwm_out | output | NUM_CH | PWM outputs |

## Verification
The hardest situation to reach is a channel whose counter sits at zero on a tick while auto-reload is being toggled and manual update is racing with start. Only short periods reach zero often enough for that to happen. The random stimulus therefore writes mostly small buffer values (0 to 7) and writes the control word often, with manual-update bits applied only now and then. It also drops tick enables at random, so the zero-count tick meets every combination of auto-reload, start and the expired state. Directed sequences first set up one reload, one expiry and one full-duty case before the random phase starts.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_COUNT   = 2'd1,
        CH_EXPIRED = 2'd2
    } ch_state_e;

    localparam int REG_CFG_A   = 'h00;
    localparam int REG_CFG_B   = 'h04;
    localparam int REG_CTRL    = 'h08;
    localparam int BUF_BASE    = 'h0C;
    localparam int BUF_STRIDE  = 12;
    localparam int CMP_OFFSET  = 4;

    // channel 0 sits in group 0, later channels skip group 1
    function automatic int ctrl_group(input int ch);
        return (ch == 0) ? 0 : ch + 1;
    endfunction

    function automatic int start_pos(input int ch);
        return 4 * ctrl_group(ch);
    endfunction

    function automatic int manual_pos(input int ch);
        return 4 * ctrl_group(ch) + 1;
    endfunction

    function automatic int invert_pos(input int ch);
        return 4 * ctrl_group(ch) + 2;
    endfunction

    // the final channel keeps its reload bit one place lower
    function automatic int reload_pos(input int ch, input int num_ch);
        return (ch == num_ch - 1) ? 4 * ctrl_group(ch) + 2 : 4 * ctrl_group(ch) + 3;
    endfunction

    function automatic logic [31:0] ctrl_mask(input int num_ch);
        logic [31:0] m;
        m = '0;
        for (int ch = 0; ch < num_ch; ch++) begin
            m[start_pos(ch)]          = 1'b1;
            m[manual_pos(ch)]         = 1'b1;
            m[reload_pos(ch, num_ch)] = 1'b1;
            if (ch != num_ch - 1) begin
                m[invert_pos(ch)] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic int period_addr(input int ch);
        return BUF_BASE + BUF_STRIDE * ch;
    endfunction

    function automatic int compare_addr(input int ch);
        return BUF_BASE + BUF_STRIDE * ch + CMP_OFFSET;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    output logic [NUM_CH-1:0]              start_o,
    output logic [NUM_CH-1:0]              manual_o,
    output logic [NUM_CH-1:0]              invert_o,
    output logic [NUM_CH-1:0]              reload_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   period_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   compare_o
);

    localparam logic [31:0] CTRL_MASK = ctrl_mask(NUM_CH);

    logic [31:0]                  cfg_a_q;
    logic [31:0]                  cfg_b_q;
    logic [31:0]                  ctrl_q;
    logic [NUM_CH-1:0][CNT_W-1:0] period_q;
    logic [NUM_CH-1:0][CNT_W-1:0] compare_q;
    int                           addr_i;

    assign addr_i = int'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a_q   <= '0;
            cfg_b_q   <= '0;
            ctrl_q    <= '0;
            period_q  <= '0;
            compare_q <= '0;
        end else if (we) begin
            if (addr_i == REG_CFG_A) cfg_a_q <= wdata;
            if (addr_i == REG_CFG_B) cfg_b_q <= wdata;
            if (addr_i == REG_CTRL)  ctrl_q  <= wdata & CTRL_MASK;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (addr_i == period_addr(ch))  period_q[ch]  <= wdata[CNT_W-1:0];
                if (addr_i == compare_addr(ch)) compare_q[ch] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_i == REG_CFG_A) rdata = cfg_a_q;
        if (addr_i == REG_CFG_B) rdata = cfg_b_q;
        if (addr_i == REG_CTRL)  rdata = ctrl_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr_i == period_addr(ch))  rdata = 32'(period_q[ch]);
            if (addr_i == compare_addr(ch)) rdata = 32'(compare_q[ch]);
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_fields
        assign start_o[g]  = ctrl_q[start_pos(g)];
        assign manual_o[g] = ctrl_q[manual_pos(g)];
        assign reload_o[g] = ctrl_q[reload_pos(g, NUM_CH)];
        if (g == NUM_CH - 1) begin : g_no_inv
            assign invert_o[g] = 1'b0;
        end else begin : g_inv
            assign invert_o[g] = ctrl_q[invert_pos(g)];
        end
    end

    assign period_o  = period_q;
    assign compare_o = compare_q;

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             manual,
    input  logic             reload,
    input  logic             invert,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_buf,
    input  logic [CNT_W-1:0] compare_buf,
    output logic             pwm
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             running;
    logic             at_zero;

    assign running = start && !manual && (state_q != CH_EXPIRED);
    assign at_zero = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (start && !manual) begin
                    state_d = (tick && at_zero && !reload) ? CH_EXPIRED : CH_COUNT;
                end
            end
            CH_COUNT: begin
                if (manual || !start)             state_d = CH_IDLE;
                else if (tick && at_zero && !reload) state_d = CH_EXPIRED;
            end
            CH_EXPIRED: begin
                if (manual || !start) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // active counter and compare registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (manual) begin
            cnt_q <= period_buf;
            cmp_q <= compare_buf;
        end else if (running && tick) begin
            if (!at_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (reload) begin
                cnt_q <= period_buf;
                cmp_q <= compare_buf;
            end
        end
    end

    // output
    always_comb begin
        pwm = (cnt_q <= cmp_q) ^ invert;
    end

    AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        manual |=> (cnt_q == $past(period_buf)) && (cmp_q == $past(compare_buf))); // R4

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && !start) |=> $stable(cnt_q) && $stable(cmp_q)); // R5

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !at_zero) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && at_zero && reload) |=> (cnt_q == $past(period_buf)) && (cmp_q == $past(compare_buf))); // R6

    AST_EXPIRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_EXPIRED && start && !manual) |=> $stable(cnt_q) && (state_q == CH_EXPIRED)); // R7

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]            start_w;
    logic [NUM_CH-1:0]            manual_w;
    logic [NUM_CH-1:0]            invert_w;
    logic [NUM_CH-1:0]            reload_w;
    logic [NUM_CH-1:0][CNT_W-1:0] period_w;
    logic [NUM_CH-1:0][CNT_W-1:0] compare_w;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .start_o   (start_w),
        .manual_o  (manual_w),
        .invert_o  (invert_w),
        .reload_o  (reload_w),
        .period_o  (period_w),
        .compare_o (compare_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_bank_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (start_w[g]),
            .manual      (manual_w[g]),
            .reload      (reload_w[g]),
            .invert      (invert_w[g]),
            .tick        (tick_en[g]),
            .period_buf  (period_w[g]),
            .compare_buf (compare_w[g]),
            .pwm         (pwm_out[g])
        );
    end

endmodule

// File: tb/test_pwm_timer_bank.sv
`timescale 1ns/1ps
module test_pwm_timer_bank;

    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_en = '0;
    logic [4:0]  pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_ctrl;
    logic [15:0] m_pbuf [NCH];
    logic [15:0] m_cbuf [NCH];
    logic [15:0] m_cnt  [NCH];
    logic [15:0] m_cmp  [NCH];
    bit          m_exp  [NCH];

    always #2 clk = ~clk;

    pwm_timer_bank i_pwm_timer_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .pwm_out   (pwm_out)
    );

    // control group base bit from R2
    function automatic int gbase(input int ch);
        return (ch == 0) ? 0 : 4 * (ch + 1);
    endfunction

    function automatic logic [31:0] exp_mask();
        logic [31:0] m = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m[gbase(ch)]     = 1'b1;
            m[gbase(ch) + 1] = 1'b1;
            m[gbase(ch) + 2] = 1'b1;
            if (ch != NCH - 1) m[gbase(ch) + 3] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [4:0] exp_out();
        logic [4:0] o;
        for (int ch = 0; ch < NCH; ch++) begin
            logic inv;
            inv = (ch == NCH - 1) ? 1'b0 : m_ctrl[gbase(ch) + 2];
            o[ch] = (m_cnt[ch] <= m_cmp[ch]) ^ inv;
        end
        return o;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic model_edge(input bit we, input logic [7:0] a, input logic [31:0] d, input logic [4:0] tk);
        for (int ch = 0; ch < NCH; ch++) begin
            bit st, mu, ar;
            st = m_ctrl[gbase(ch)];
            mu = m_ctrl[gbase(ch) + 1];
            ar = (ch == NCH - 1) ? m_ctrl[gbase(ch) + 2] : m_ctrl[gbase(ch) + 3];
            if (mu) begin
                m_cnt[ch] = m_pbuf[ch];
                m_cmp[ch] = m_cbuf[ch];
                m_exp[ch] = 0;
            end else if (!st) begin
                m_exp[ch] = 0;
            end else if (!m_exp[ch] && tk[ch]) begin
                if (m_cnt[ch] != 0) m_cnt[ch] = m_cnt[ch] - 16'd1;
                else if (ar) begin
                    m_cnt[ch] = m_pbuf[ch];
                    m_cmp[ch] = m_cbuf[ch];
                end else m_exp[ch] = 1;
            end
        end
        if (we) begin
            if (a == 8'h08) m_ctrl = d & exp_mask();
            for (int ch = 0; ch < NCH; ch++) begin
                if (int'(a) == 12 + 12 * ch) m_pbuf[ch] = d[15:0];
                if (int'(a) == 16 + 12 * ch) m_cbuf[ch] = d[15:0];
            end
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [4:0] tk, input string tag);
        bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(posedge clk);
        model_edge(we, a, d, tk);
        @(negedge clk);
        bus_we = 1'b0;
        check(pwm_out == exp_out(), tag, {27'd0, pwm_out}, {27'd0, exp_out()});
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(bus_rdata == expv, tag, bus_rdata, expv);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m_pbuf[ch] = '0; m_cbuf[ch] = '0; m_cnt[ch] = '0; m_cmp[ch] = '0; m_exp[ch] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check(pwm_out == 5'h1F, "R9 outputs after reset", {27'd0, pwm_out}, 32'h1F);
        for (int a = 0; a < 'h48; a += 4) rd(8'(a), 32'h0, "R9 readback after reset");

        // R1 register map
        cyc(1, 8'h00, 32'hA5A5_1234, 5'h0, "R1 write");
        cyc(1, 8'h04, 32'h0F0F_8001, 5'h0, "R1 write");
        cyc(1, 8'h24, 32'h0001_2345, 5'h0, "R1 write");
        cyc(1, 8'h28, 32'hFFFF_0007, 5'h0, "R1 write");
        rd(8'h00, 32'hA5A5_1234, "R1 cfg word A");
        rd(8'h04, 32'h0F0F_8001, "R1 cfg word B");
        rd(8'h24, 32'h0000_2345, "R1 period buffer truncation");
        rd(8'h28, 32'h0000_0007, "R1 compare buffer");
        rd(8'h14, 32'h0, "R1 unused address");
        rd(8'h44, 32'h0, "R1 unused address");

        // R2 R3 control layout
        cyc(1, 8'h08, 32'hFFFF_FFFF & ~32'h0022_2202, 5'h0, "R2 write");
        rd(8'h08, exp_mask() & ~32'h0022_2202, "R2 R3 control mask readback");
        rd(8'h08, 32'h005D_DD0D, "R2 R3 control literal");
        cyc(1, 8'h08, 32'h0, 5'h0, "R2 clear");

        // R4 R5 R6 R8 channel 0: period 3, compare 1, reload
        cyc(1, 8'h0C, 32'd3, 5'h0, "R4 setup");
        cyc(1, 8'h10, 32'd1, 5'h0, "R4 setup");
        cyc(1, 8'h08, 32'h2, 5'h0, "R4 manual");
        cyc(0, 8'h00, 32'h0, 5'h0, "R4 manual load");
        check(pwm_out[0] == 1'b0, "R4 R8 loaded counter 3 above compare 1", {31'd0, pwm_out[0]}, 32'd0);
        cyc(1, 8'h08, 32'h9, 5'h0, "R5 start");
        cyc(0, 8'h00, 32'h0, 5'h0, "R5 no tick holds");
        for (int i = 0; i < 12; i++) cyc(0, 8'h00, 32'h0, 5'h1, "R5 R6 R8 reload run");
        cyc(1, 8'h08, 32'h0, 5'h1, "R5 stop");
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 32'h0, 5'h1, "R5 stopped holds");

        // R7 channel 1 expiry
        cyc(1, 8'h18, 32'd2, 5'h0, "R7 setup");
        cyc(1, 8'h1C, 32'd0, 5'h0, "R7 setup");
        cyc(1, 8'h08, 32'h200, 5'h0, "R7 manual");
        cyc(1, 8'h08, 32'h100, 5'h0, "R7 start no reload");
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 32'h0, 5'h2, "R7 expire and hold");
        cyc(1, 8'h18, 32'd5, 5'h0, "R7 new buffer");
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 32'h0, 5'h2, "R7 expired ignores buffer");

        // R8 full duty and inversion, channel 2
        cyc(1, 8'h24, 32'd4, 5'h0, "R8 setup");
        cyc(1, 8'h28, 32'hFFFF, 5'h0, "R8 setup");
        cyc(1, 8'h08, 32'h2000, 5'h0, "R8 manual");
        cyc(1, 8'h08, 32'h9000, 5'h0, "R8 start");
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 32'h0, 5'h4, "R8 full duty");
        check(pwm_out[2] == 1'b1, "R8 constant high", {31'd0, pwm_out[2]}, 32'd1);
        cyc(1, 8'h08, 32'hD000, 5'h0, "R8 invert");
        check(pwm_out[2] == 1'b0, "R8 inverted full duty", {31'd0, pwm_out[2]}, 32'd0);

        // R3 last channel reload at bit 22
        cyc(1, 8'h3C, 32'd2, 5'h0, "R3 setup");
        cyc(1, 8'h40, 32'd1, 5'h0, "R3 setup");
        cyc(1, 8'h08, 32'h0020_0000, 5'h0, "R3 manual");
        cyc(1, 8'h08, 32'h0050_0000, 5'h0, "R3 start reload");
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 32'h0, 5'h10, "R3 last channel reloads");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit we;
            logic [7:0] a;
            logic [31:0] d;
            we = ($urandom % 5) == 0;
            a = 8'h00; d = 32'h0;
            if (we) begin
                int ch;
                ch = $urandom % NCH;
                case ($urandom % 3)
                    0: begin
                        a = 8'h08;
                        d = $urandom;
                        if (($urandom % 4) != 0) begin
                            for (int c = 0; c < NCH; c++) d[gbase(c) + 1] = 1'b0;
                        end
                    end
                    1: begin a = 8'(12 + 12 * ch); d = $urandom % 8; end
                    default: begin
                        a = 8'(16 + 12 * ch);
                        d = (($urandom % 6) == 0) ? 32'hFFFF : 32'($urandom % 8);
                    end
                endcase
            end
            cyc(we, a, d, 5'($urandom), "R4 R5 R6 R7 R8 random");
        end
        rd(8'h08, m_ctrl, "R2 control after random");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule